// File: doc/BRIEF.md
# Timer Channel Output Compare Unit

This block is one output channel of a timer. It watches a selected time base and compares it against two match values, A and B, held on input pins. On a match it updates a single output flip-flop and raises a sticky match flag. The flag is cleared by a write-one-to-clear strobe. A mode input picks one of three behaviours. In input mode the channel takes no output action. In single-action compare only comparator A acts, and each match either loads the polarity bit or toggles the output. In dual compare one comparator sets the output and the other clears it, with the polarity bit deciding which does which.

The time base comes from a 2-bit bus select. It can pick a counter bus shared by every channel, a grouped bus chosen by the channel's index (parameter `CH_IDX`, eight channels per group), or a free-running counter private to the channel. The remaining select code is reserved: while it is applied the channel freezes its output and flag. A software strobe can force a comparator B action on the output without touching the flag. All ports are plain control and status pins; the block has no data stream, so no handshake applies.

Top module: `oc_channel`

## Requirements
- R1: While rst_n is low, out_o and flag_o are 0.
- R2: In dual compare (mode_i = 2'b10) with pol_i = 0, a comparator A match drives out_o to 0 and a comparator B match drives it to 1, visible after the clock edge that ends the matching cycle.
- R3: In dual compare with pol_i = 1, a comparator A match drives out_o to 1 and a comparator B match drives it to 0.
- R4: In single-action compare (mode_i = 2'b01), only comparator A acts. With edsel_i = 0 a match loads pol_i into out_o. With edsel_i = 1 a match inverts out_o. A comparator B match changes neither out_o nor flag_o.
- R5: In dual compare, a one-cycle pulse on force_b_i acts on out_o exactly like a comparator B match and leaves flag_o unchanged.
- R6: force_b_i has no effect on out_o or flag_o in single-action compare or in input mode.
- R7: flag_o becomes 1 after the edge that ends a cycle in which a comparator used by the mode matches: A in single-action, A or B in dual. flag_o stays 1 until a cycle with flag_clr_i = 1 and no such match. A real B match together with force_b_i applies the B action once and still sets flag_o.
- R8: bsel_i picks the time base. 2'b00 selects bus_a_i. 2'b01 selects group bus CH_IDX/8 of bus_grp_i, whose group g sits at bits [g*CNT_W +: CNT_W]. 2'b11 selects the internal counter. The buses that are not selected cannot cause a match.
- R9: While bsel_i = 2'b10, out_o and flag_o hold their values, and neither the buses nor force_b_i change them.
- R10: The internal counter is 0 when reset ends and increments by one on every clock edge, wrapping at its width.
- R11: In input mode (mode_i = 2'b00 or 2'b11), matches on A or B change neither out_o nor flag_o.
- R12: In dual compare, when A and B match in the same cycle, the B action wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00/11 input, 01 single-action compare, 10 dual compare |
| pol_i | input | 1 | Output polarity bit |
| edsel_i | input | 1 | Single-action: 0 load polarity, 1 toggle |
| bsel_i | input | 2 | Time-base select |
| force_b_i | input | 1 | Strobe that forces a comparator B action |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| match_a_i | input | CNT_W | Comparator A match value |
| match_b_i | input | CNT_W | Comparator B match value |
| bus_a_i | input | CNT_W | Counter bus shared by all channels |
| bus_grp_i | input | N_GRP*CNT_W | Grouped counter buses, one per group of eight channels |
| out_o | output | 1 | Output flip-flop |
| flag_o | output | 1 | Sticky match flag |

## Verification
The bench targets the cases where the output actions collide or where a source must be ignored. When A and B match in the same cycle, a design with the priority reversed would leave the output at the A level. When a forced B lands on the same cycle as a real B, a design that lets the force path mask the real match would lose the flag. A forced B must leave the flag untouched, and the force must do nothing in single-action and input modes; a loose design would set the flag or move the output there. The bench also drives a matching value on every unselected bus, and on all buses under the reserved select, to catch a multiplexer that picks the wrong group or leaks a match. The internal counter is checked against a model counter, so an off-by-one in its reset value or in the compare timing shifts the output by one cycle and is reported.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OC_MODE_IN0  = 2'b00,
    OC_MODE_SAOC = 2'b01,
    OC_MODE_DUAL = 2'b10,
    OC_MODE_IN3  = 2'b11
  } oc_mode_e;

  localparam logic [1:0] OC_BSEL_SHARED = 2'b00;
  localparam logic [1:0] OC_BSEL_GROUP  = 2'b01;
  localparam logic [1:0] OC_BSEL_RSV    = 2'b10;
  localparam logic [1:0] OC_BSEL_LOCAL  = 2'b11;

  localparam int OC_CH_PER_GRP = 8;
endpackage

// File: rtl/oc_intcnt.sv
module oc_intcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);
  // free-running private time base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_o <= '0;
    else        cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> cnt_o == $past(cnt_o) + 1'b1); // R10
endmodule

// File: rtl/oc_busmux.sv
module oc_busmux
  import oc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_GRP  = 4,
  parameter int CH_IDX = 10
) (
  input  logic [1:0]             bsel_i,
  input  logic [CNT_W-1:0]       bus_a_i,
  input  logic [N_GRP*CNT_W-1:0] bus_grp_i,
  input  logic [CNT_W-1:0]       local_i,
  output logic [CNT_W-1:0]       sel_o,
  output logic                   sel_ok_o
);
  localparam int GRP = CH_IDX / OC_CH_PER_GRP;

  logic [CNT_W-1:0] grp_bus;

  // pick the group bus that serves this channel
  always_comb begin
    grp_bus = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (g == GRP) grp_bus = bus_grp_i[g*CNT_W +: CNT_W];
    end
  end

  always_comb begin
    sel_o    = '0;
    sel_ok_o = 1'b1;
    unique case (bsel_i)
      OC_BSEL_SHARED: sel_o = bus_a_i;
      OC_BSEL_GROUP:  sel_o = grp_bus;
      OC_BSEL_LOCAL:  sel_o = local_i;
      default:        sel_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/oc_match.sv
module oc_match #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_ok_i,
  input  logic [CNT_W-1:0] match_a_i,
  input  logic [CNT_W-1:0] match_b_i,
  output logic             hit_a_o,
  output logic             hit_b_o
);
  // equality comparators, blanked when no valid time base is selected
  always_comb begin
    hit_a_o = cnt_ok_i && (cnt_i == match_a_i);
    hit_b_o = cnt_ok_i && (cnt_i == match_b_i);
  end
endmodule

// File: rtl/oc_action.sv
module oc_action
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  oc_mode_e   mode_i,
  input  logic       pol_i,
  input  logic       edsel_i,
  input  logic       sel_ok_i,
  input  logic       hit_a_i,
  input  logic       hit_b_i,
  input  logic       force_b_i,
  input  logic       flag_clr_i,
  output logic       out_o,
  output logic       flag_o
);
  logic use_a, use_b, ev_a, ev_b, act_b;
  logic out_d, flag_d;

  always_comb begin
    use_a = (mode_i == OC_MODE_SAOC) || (mode_i == OC_MODE_DUAL);
    use_b = (mode_i == OC_MODE_DUAL);
    ev_a  = use_a && hit_a_i;
    ev_b  = use_b && hit_b_i;
    // forced B only where comparator B is in use and a time base is valid
    act_b = ev_b || (use_b && sel_ok_i && force_b_i);
  end

  always_comb begin
    out_d = out_o;
    if (mode_i == OC_MODE_SAOC) begin
      if (ev_a) out_d = edsel_i ? ~out_o : pol_i;
    end else if (mode_i == OC_MODE_DUAL) begin
      if (act_b)     out_d = ~pol_i;   // B wins a tie
      else if (ev_a) out_d = pol_i;
    end
  end

  always_comb begin
    if (ev_a || ev_b)   flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
    else                flag_d = flag_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      out_o  <= out_d;
      flag_o <= flag_d;
    end
  end

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (!flag_o && !hit_a_i && !hit_b_i) |=> !flag_o); // R5
  AST_SAOC_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (mode_i == OC_MODE_SAOC && !edsel_i && hit_a_i) |=> out_o == $past(pol_i)); // R4
  AST_SAOC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) (mode_i == OC_MODE_SAOC && edsel_i && hit_a_i) |=> out_o != $past(out_o)); // R4
  AST_DUAL_B_WINS: assert property (@(posedge clk) disable iff (!rst_n) (mode_i == OC_MODE_DUAL && sel_ok_i && (hit_b_i || force_b_i)) |=> out_o == !$past(pol_i)); // R12
  AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mode_i == OC_MODE_IN0 || mode_i == OC_MODE_IN3) |=> ($stable(out_o) && !$rose(flag_o))); // R11
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) (mode_i == OC_MODE_DUAL && (hit_a_i || hit_b_i)) |=> flag_o); // R7
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_GRP  = 4,
  parameter int CH_IDX = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_i,
  input  logic                   pol_i,
  input  logic                   edsel_i,
  input  logic [1:0]             bsel_i,
  input  logic                   force_b_i,
  input  logic                   flag_clr_i,
  input  logic [CNT_W-1:0]       match_a_i,
  input  logic [CNT_W-1:0]       match_b_i,
  input  logic [CNT_W-1:0]       bus_a_i,
  input  logic [N_GRP*CNT_W-1:0] bus_grp_i,
  output logic                   out_o,
  output logic                   flag_o
);
  logic [CNT_W-1:0] local_cnt;
  logic [CNT_W-1:0] sel_cnt;
  logic             sel_ok;
  logic             hit_a, hit_b;
  oc_mode_e         mode;

  assign mode = oc_mode_e'(mode_i);

  oc_intcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (local_cnt)
  );

  oc_busmux #(.CNT_W(CNT_W), .N_GRP(N_GRP), .CH_IDX(CH_IDX)) u_mux (
    .bsel_i    (bsel_i),
    .bus_a_i   (bus_a_i),
    .bus_grp_i (bus_grp_i),
    .local_i   (local_cnt),
    .sel_o     (sel_cnt),
    .sel_ok_o  (sel_ok)
  );

  oc_match #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i     (sel_cnt),
    .cnt_ok_i  (sel_ok),
    .match_a_i (match_a_i),
    .match_b_i (match_b_i),
    .hit_a_o   (hit_a),
    .hit_b_o   (hit_b)
  );

  oc_action u_act (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .pol_i      (pol_i),
    .edsel_i    (edsel_i),
    .sel_ok_i   (sel_ok),
    .hit_a_i    (hit_a),
    .hit_b_i    (hit_b),
    .force_b_i  (force_b_i),
    .flag_clr_i (flag_clr_i),
    .out_o      (out_o),
    .flag_o     (flag_o)
  );

  AST_RSV_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (bsel_i == OC_BSEL_RSV) |=> ($stable(out_o) && !$rose(flag_o))); // R9
  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |-> (!out_o && !flag_o)); // R1
endmodule

// File: tb/oc_channel_test.sv
module oc_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [W-1:0] IDLE = 16'hFFFF;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b00, bsel = 2'b00;
  logic pol = 0, edsel = 0, force_b = 0, clr = 0;
  logic [W-1:0] ma = 16'd100, mb = 16'd200, bus_a = IDLE;
  logic [4*W-1:0] grp = {4{IDLE}};
  logic out, flag;
  logic [W-1:0] mdl;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // model of the private counter, built from R10
  always @(posedge clk or negedge rst_n)
    if (!rst_n) mdl <= '0; else mdl <= mdl + 1'b1;

  oc_channel uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .pol_i(pol), .edsel_i(edsel),
    .bsel_i(bsel), .force_b_i(force_b), .flag_clr_i(clr),
    .match_a_i(ma), .match_b_i(mb), .bus_a_i(bus_a), .bus_grp_i(grp),
    .out_o(out), .flag_o(flag)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic hit_a_bus(input logic [W-1:0] v);
    bus_a = v; step(); bus_a = IDLE;
  endtask

  task automatic clear_flag();
    clr = 1; step(); clr = 0;
  endtask

  task automatic t_reset();
    check("R1 out after reset", out, 1'b0);
    check("R1 flag after reset", flag, 1'b0);
  endtask

  task automatic t_dual_pol0();
    mode = 2'b10; pol = 0; bsel = 2'b00;
    hit_a_bus(mb);
    check("R2 B sets", out, 1'b1);
    check("R7 flag on B", flag, 1'b1);
    clear_flag();
    check("R7 w1c clears", flag, 1'b0);
    hit_a_bus(ma);
    check("R2 A clears", out, 1'b0);
    check("R7 flag on A", flag, 1'b1);
    clr = 1; bus_a = ma; step(); clr = 0; bus_a = IDLE;
    check("R7 set beats clear", flag, 1'b1);
  endtask

  task automatic t_dual_pol1();
    pol = 1;
    hit_a_bus(ma);
    check("R3 A sets", out, 1'b1);
    hit_a_bus(mb);
    check("R3 B clears", out, 1'b0);
  endtask

  task automatic t_tie();
    pol = 0; ma = 16'd300; mb = 16'd300;
    hit_a_bus(16'd300);
    check("R12 B wins tie", out, 1'b1);
    ma = 16'd100; mb = 16'd200;
  endtask

  task automatic t_saoc();
    mode = 2'b01; edsel = 0; pol = 0;
    hit_a_bus(ma);
    check("R4 load pol 0", out, 1'b0);
    pol = 1;
    hit_a_bus(ma);
    check("R4 load pol 1", out, 1'b1);
    clear_flag();
    pol = 0;
    hit_a_bus(mb);
    check("R4 B ignored out", out, 1'b1);
    check("R4 B ignored flag", flag, 1'b0);
    edsel = 1;
    hit_a_bus(ma);
    check("R4 toggle 1", out, 1'b0);
    hit_a_bus(ma);
    check("R4 toggle 2", out, 1'b1);
    edsel = 0;
  endtask

  task automatic t_force();
    mode = 2'b10; pol = 0;
    hit_a_bus(ma);
    clear_flag();
    check("R5 pre out", out, 1'b0);
    force_b = 1; step(); force_b = 0;
    check("R5 force acts", out, 1'b1);
    check("R5 force no flag", flag, 1'b0);
    pol = 1;
    force_b = 1; bus_a = mb; step(); force_b = 0; bus_a = IDLE;
    check("R7 force+B out", out, 1'b0);
    check("R7 force+B flag", flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_force_ignored();
    logic keep;
    mode = 2'b01; keep = out;
    force_b = 1; step(); force_b = 0;
    check("R6 saoc force out", out, keep);
    check("R6 saoc force flag", flag, 1'b0);
    mode = 2'b00;
    force_b = 1; step(); force_b = 0;
    check("R6 input force out", out, keep);
    hit_a_bus(ma); hit_a_bus(mb);
    check("R11 input mode out", out, keep);
    check("R11 input mode flag", flag, 1'b0);
    mode = 2'b11;
    hit_a_bus(ma); hit_a_bus(mb);
    check("R11 mode 11 out", out, keep);
  endtask

  task automatic t_bsel();
    mode = 2'b10; pol = 0;
    hit_a_bus(ma);
    clear_flag();
    bsel = 2'b01;
    bus_a = mb; grp[0 +: W] = mb; grp[2*W +: W] = mb; grp[3*W +: W] = mb;
    step();
    check("R8 wrong buses ignored", out, 1'b0);
    check("R8 wrong buses no flag", flag, 1'b0);
    grp = {4{IDLE}}; bus_a = IDLE;
    grp[W +: W] = mb; step(); grp = {4{IDLE}};
    check("R8 group bus C", out, 1'b1);
    bsel = 2'b00;
    grp[W +: W] = ma; step(); grp = {4{IDLE}};
    check("R8 group unused on 00", out, 1'b1);
    clear_flag();
  endtask

  task automatic t_rsv();
    bsel = 2'b10;
    bus_a = ma; grp = {4{ma}}; force_b = 1; pol = 1;
    step(); step();
    force_b = 0; bus_a = IDLE; grp = {4{IDLE}};
    check("R9 reserved out", out, 1'b1);
    check("R9 reserved flag", flag, 1'b0);
    pol = 0; bsel = 2'b00;
  endtask

  task automatic t_local();
    // out is 1; A (pol 0) will clear it
    ma = mdl + 16'd3; mb = mdl + 16'd1000; bsel = 2'b11;
    step(); step(); step();
    check("R10 before local match", out, 1'b1);
    step();
    check("R10 at local match", out, 1'b0);
    check("R10 local flag", flag, 1'b1);
    bsel = 2'b00; ma = 16'd100; mb = 16'd200;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_dual_pol0();
    t_dual_pol1();
    t_tie();
    t_saoc();
    t_force();
    t_force_ignored();
    t_bsel();
    t_rsv();
    t_local();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule